// File: doc/BRIEF.md
# Multicore snoop-unit register file

This block is the register window of the snoop unit in a small multicore cluster. It answers a simple register bus with one read strobe, one write strobe, a byte offset within a 256-byte window, 32-bit data and an access-size field that counts bytes. Three registers hold state or are computed: an enable register of one bit, a read-only cluster description built from the core-count parameter, and a 32-bit per-core power state word. The power state word can be read and written a byte or a halfword at a time through four adjacent byte offsets.

The other functions of a snoop unit have stub offsets here. These are bulk invalidate, address-range filtering and secure access control. Each of them reads as zero and does nothing on a write. Read data is registered. It appears one clock after the read strobe and holds until the next read. A synchronous active-high reset clears the enable register. The power state word is not touched by reset: it starts at zero at power-up and keeps its contents across every later reset.

Top module: `snoop_csr`

## Requirements
- R1: A write to offset 0x00 stores bit 0 of the write data. A read of offset 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R2: A read of offset 0x04 returns bits 3:0 = NUM_CORES-1 and bits 7:4 = a run of NUM_CORES ones from bit 4 upward, with all other bits zero. This gives 0x10 for one core and 0xF3 for four. Writes to 0x04 change nothing.
- R3: A read of offset 0x08+k (k = 0..3) returns the power state word shifted right by 8·k bits, with zeros filling the top.
- R4: A write at offset 0x08+k uses a mask of 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. It loads the masked write data, shifted left by 8·k, into the bits that the equally shifted mask selects. Bits shifted beyond bit 31 are dropped, and every other bit of the word is kept.
- R5: A write whose size field is not 1, 2 or 4 leaves the enable register and the power state word unchanged.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every offset not named in R1 to R3, read as zero. A write to any of them changes no register.
- R7: Reset clears the enable register and leaves the power state word unchanged. The power state word is zero after power-up.
- R8: Read data is loaded at the clock edge that samples the read strobe and holds its value in cycles without a read.
- R9: NUM_CORES defaults to 1 and is limited to the range 1 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| bus_wdata | input | 32 | Write data, least significant byte first |
| bus_rdata | output | 32 | Registered read data |

## Verification
A wrong lane shift or mask in the power state word shows at the next read of any of the four power offsets, one clock after that read's strobe. The read-back at several offsets tells a bad shift apart from a bad mask. A write that leaks through a bad size or a stub offset is found only when the enable register or the power word is read back afterwards. The bench therefore reads both after every such write. A reset that wrongly clears the power word shows on the first read after reset.

// File: rtl/snoop_csr_pkg.sv
package snoop_csr_pkg;

  localparam int CSR_DW = 32;
  localparam int CSR_AW = 8;

  // Offsets the decoder recognises
  localparam logic [CSR_AW-1:0] OFS_ENABLE  = 8'h00;
  localparam logic [CSR_AW-1:0] OFS_CLUSTER = 8'h04;
  localparam logic [CSR_AW-1:0] OFS_PSTATE  = 8'h08; // through 0x0B

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_CLUSTER = 2'd2,
    SEL_PSTATE  = 2'd3
  } csr_sel_e;

  // Byte count to unshifted lane mask; zero for unsupported sizes
  function automatic logic [CSR_DW-1:0] size_to_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    size_to_mask = 32'h0000_00FF;
      3'd2:    size_to_mask = 32'h0000_FFFF;
      3'd4:    size_to_mask = 32'hFFFF_FFFF;
      default: size_to_mask = '0;
    endcase
  endfunction

endpackage

// File: rtl/snoop_csr_decode.sv
module snoop_csr_decode
  import snoop_csr_pkg::*;
#(
  parameter int AW = CSR_AW,
  parameter int DW = CSR_DW
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    nbytes,
  output csr_sel_e      sel,
  output logic [1:0]    lane,
  output logic          size_ok,
  output logic [DW-1:0] lane_mask
);
  logic [DW-1:0] base_mask;

  always_comb begin
    lane = addr[1:0];
    if (addr == OFS_ENABLE)
      sel = SEL_ENABLE;
    else if (addr == OFS_CLUSTER)
      sel = SEL_CLUSTER;
    else if (addr[AW-1:2] == OFS_PSTATE[AW-1:2])
      sel = SEL_PSTATE;
    else
      sel = SEL_NONE;
  end

  assign base_mask = size_to_mask(nbytes);
  assign size_ok   = |base_mask;
  // shift by whole bytes; bits beyond the word top are dropped
  assign lane_mask = base_mask << {lane, 3'b000};
endmodule

// File: rtl/snoop_csr_pstate.sv
module snoop_csr_pstate
  import snoop_csr_pkg::*;
#(
  parameter int DW = CSR_DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [1:0]    lane,
  input  logic [DW-1:0] lane_mask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word
);
  localparam int NBYTE = DW / 8;

  logic [DW-1:0] wdata_sh;
  assign wdata_sh = wdata << {lane, 3'b000};

  // Power-up value only; reset deliberately does not reach this word
  logic [DW-1:0] word_q = '0;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (we && lane_mask[8*b])
        word_q[8*b +: 8] <= wdata_sh[8*b +: 8];
    end
  end

  assign word = word_q;
endmodule

// File: rtl/snoop_csr_rdmux.sv
module snoop_csr_rdmux
  import snoop_csr_pkg::*;
#(
  parameter int DW = CSR_DW
) (
  input  csr_sel_e      sel,
  input  logic [1:0]    lane,
  input  logic          enable,
  input  logic [DW-1:0] cluster,
  input  logic [DW-1:0] pstate,
  output logic [DW-1:0] data
);
  always_comb begin
    case (sel)
      SEL_ENABLE:  data = {{(DW-1){1'b0}}, enable};
      SEL_CLUSTER: data = cluster;
      SEL_PSTATE:  data = pstate >> {lane, 3'b000};
      default:     data = '0;
    endcase
  end
endmodule

// File: rtl/snoop_csr.sv
module snoop_csr
  import snoop_csr_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CSR_AW-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [CSR_DW-1:0] bus_wdata,
  output logic [CSR_DW-1:0] bus_rdata
);
  localparam logic [3:0] CORE_ONES = 4'((1 << NUM_CORES) - 1);
  localparam logic [3:0] CORE_LAST = 4'(NUM_CORES - 1);
  localparam logic [CSR_DW-1:0] CLUSTER_WORD = {{(CSR_DW-8){1'b0}}, CORE_ONES, CORE_LAST};

  csr_sel_e          sel;
  logic [1:0]        lane;
  logic              size_ok;
  logic [CSR_DW-1:0] lane_mask;
  logic              enable_q;
  logic [CSR_DW-1:0] pstate_word;
  logic [CSR_DW-1:0] rd_mux;
  logic              wr_ok;

  snoop_csr_decode #(.AW(CSR_AW), .DW(CSR_DW)) u_dec (
    .addr(bus_addr), .nbytes(bus_size), .sel(sel), .lane(lane),
    .size_ok(size_ok), .lane_mask(lane_mask)
  );

  assign wr_ok = bus_wr && size_ok;

  always_ff @(posedge clk) begin
    if (rst)
      enable_q <= 1'b0;
    else if (wr_ok && sel == SEL_ENABLE)
      enable_q <= bus_wdata[0];
  end

  snoop_csr_pstate #(.DW(CSR_DW)) u_pst (
    .clk(clk), .we(wr_ok && sel == SEL_PSTATE), .lane(lane),
    .lane_mask(lane_mask), .wdata(bus_wdata), .word(pstate_word)
  );

  snoop_csr_rdmux #(.DW(CSR_DW)) u_rmux (
    .sel(sel), .lane(lane), .enable(enable_q), .cluster(CLUSTER_WORD),
    .pstate(pstate_word), .data(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/snoop_csr_chk.sv
module snoop_csr_chk
  import snoop_csr_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [CSR_AW-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [CSR_DW-1:0] bus_wdata,
  input logic [CSR_DW-1:0] bus_rdata,
  input logic              enable_q,
  input logic [CSR_DW-1:0] pstate_word
);
  localparam logic [CSR_DW-1:0] EXP_CLUSTER =
    CSR_DW'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1));

  logic bad_size;
  logic stub_ofs;
  assign bad_size = !(bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4);
  assign stub_ofs = (bus_addr == 8'h0C) || (bus_addr == 8'h40) || (bus_addr == 8'h44)
                 || (bus_addr == 8'h50) || (bus_addr == 8'h54) || (bus_addr >= 8'h80);

  // R9: core count kept in range
  initial a_r9_core_range: assert (NUM_CORES >= 1 && NUM_CORES <= 4);

  a_r1_enable_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h00) |=> (bus_rdata[CSR_DW-1:1] == '0));

  a_r2_cluster_word: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h04) |=> (bus_rdata == EXP_CLUSTER));

  a_r4_full_word_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h08 && bus_size == 3'd4) |=> (pstate_word == $past(bus_wdata)));

  a_r5_bad_size_no_effect: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bad_size) |=> ($stable(pstate_word) && $stable(enable_q)));

  a_r6_stub_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && stub_ofs) |=> (bus_rdata == '0));

  a_r6_stub_write_inert: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && stub_ofs) |=> ($stable(pstate_word) && $stable(enable_q)));

  a_r7_reset_clears_enable: assert property (@(posedge clk)
    rst |=> !enable_q);

  a_r7_reset_keeps_pstate: assert property (@(posedge clk)
    (rst && !bus_wr) |=> $stable(pstate_word));

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind snoop_csr snoop_csr_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .enable_q(enable_q), .pstate_word(pstate_word)
);

// File: tb/test_snoop_csr.sv
module test_snoop_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] rdata4;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] m_pst = '0;
  logic        m_en = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  snoop_csr i_snoop_csr (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  snoop_csr #(.NUM_CORES(4)) i_snoop_csr4 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata4)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // Model of the lane write from R4
  function automatic logic [31:0] lane_write(input logic [31:0] old, input logic [1:0] k,
                                             input logic [31:0] d, input logic [2:0] s);
    logic [31:0] m;
    m = (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (old & ~(m << (8 * k))) | ((d & m) << (8 * k));
  endfunction

  task automatic pwr_write(input logic [1:0] k, input logic [31:0] d, input logic [2:0] s);
    wr(8'h08 + 8'(k), d, s);
    m_pst = lane_write(m_pst, k, d, s);
  endtask

  task automatic check_all_lanes(input string req);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(8'h08 + 8'(k), v);
      check(req, v, m_pst >> (8 * k));
    end
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(8'h00, v); check("R7 enable after reset", v, 32'h0);
    rd(8'h08, v); check("R7 power-up pstate", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF, 3'd4); rd(8'h00, v); check("R1 enable set", v, 32'h1);
    wr(8'h00, 32'hFFFF_FFFE, 3'd4); rd(8'h00, v); check("R1 enable clear", v, 32'h0);
    wr(8'h00, 32'h0000_0003, 3'd1); rd(8'h00, v); check("R1 enable byte write", v, 32'h1);
    m_en = 1'b1;
  endtask

  task automatic t_cluster;
    logic [31:0] v;
    rd(8'h04, v);
    check("R2/R9 default cores", v, 32'h10);
    check("R2 four cores", rdata4, 32'hF3);
    wr(8'h04, 32'hFFFF_FFFF, 3'd4);
    rd(8'h04, v);
    check("R2 write ignored", v, 32'h10);
    check("R2 write ignored x4", rdata4, 32'hF3);
  endtask

  task automatic t_pstate;
    pwr_write(2'd0, 32'h1122_3344, 3'd4); check_all_lanes("R3 full word");
    pwr_write(2'd1, 32'h0000_00AB, 3'd1); check_all_lanes("R4 byte lane 1");
    pwr_write(2'd2, 32'h0000_BEEF, 3'd2); check_all_lanes("R4 half lane 2");
    pwr_write(2'd3, 32'h0000_5A6B, 3'd2); check_all_lanes("R4 half at top truncated");
    pwr_write(2'd2, 32'hCAFE_D00D, 3'd4); check_all_lanes("R4 word at lane 2");
    pwr_write(2'd0, 32'h0000_0077, 3'd1); check_all_lanes("R4 byte lane 0");
  endtask

  task automatic t_bad_size;
    logic [31:0] v;
    logic [2:0] bad [4] = '{3'd0, 3'd3, 3'd5, 3'd7};
    for (int i = 0; i < 4; i++) begin
      wr(8'h08, 32'h0, bad[i]);
      wr(8'h00, 32'h0, bad[i]);
    end
    rd(8'h08, v); check("R5 pstate kept", v, m_pst);
    rd(8'h00, v); check("R5 enable kept", v, 32'(m_en));
  endtask

  task automatic t_stubs;
    logic [31:0] v;
    logic [7:0] ofs [9] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'h0D, 8'h80, 8'hFC};
    for (int i = 0; i < 9; i++) begin
      wr(ofs[i], 32'hFFFF_FFFF, 3'd4);
      rd(ofs[i], v);
      check("R6 stub reads zero", v, 32'h0);
    end
    rd(8'h08, v); check("R6 pstate untouched", v, m_pst);
    rd(8'h00, v); check("R6 enable untouched", v, 32'(m_en));
  endtask

  task automatic t_reset_keeps;
    logic [31:0] v;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_en = 1'b0;
    rd(8'h00, v); check("R7 enable cleared", v, 32'h0);
    rd(8'h08, v); check("R7 pstate survives reset", v, m_pst);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    rd(8'h04, v);
    check("R8 one-cycle read", v, 32'h10);
    @(negedge clk); bus_addr = 8'h08;
    repeat (3) @(negedge clk);
    check("R8 holds without read", bus_rdata, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_enable();
    t_cluster();
    t_pstate();
    t_bad_size();
    t_stubs();
    t_reset_keeps();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule